// File: doc/BRIEF.md
# Chained Byte Subtract and Compare Unit

This unit is the subtract/compare slice of a small processor datapath. It works on a byte at a time. A 3-bit operation code selects one of six operations: subtract, subtract with borrow, compare, compare with borrow, and the two constant forms of subtract. The constant forms take an 8-bit constant in place of the second register operand. The result and a fresh set of status flags come out one clock after the operands are presented. The write strobe tells the register file whether to store the byte.

Wider numbers are handled by issuing one operation per byte, lowest byte first. The caller feeds the flags from each step into the next one. The borrow-consuming forms chain both the borrow and the zero flag, so after the last byte the zero flag reports equality of the whole word. The borrow flag reports unsigned less-than and the sign flag reports signed less-than.

There is no add-constant operation. Adding a constant k is done by subtracting its two's complement, starting with the low byte and continuing with borrow. For example, adding 5 to a 16-bit value means subtracting 0xFB from the low byte and then 0xFF from the high byte with borrow.

Top module: `sbc_alu`

## Requirements
- R1: Operation code 0 (subtract) outputs result = A - B modulo 256 with result_we = 1, and the flags come from that result alone.
- R2: Operation code 1 (subtract with borrow) outputs result = A - B - Cin modulo 256 with result_we = 1, where Cin is flags_in bit 0.
- R3: Operation code 2 (compare) produces the same flags as subtract but drives result_we = 0.
- R4: Operation code 3 (compare with borrow) produces the same flags as subtract with borrow but drives result_we = 0.
- R5: Operation codes 4 and 5 behave like codes 0 and 1 but use the imm input in place of B, and B has no effect on them.
- R6: The carry flag (flags bit 0) is 1 exactly when the unsigned value B + Cin is greater than A, where Cin is 0 for codes 0, 2 and 4.
- R7: The zero flag (flags bit 1) is result == 0 for codes 0, 2 and 4. For codes 1, 3 and 5 it is (result == 0) AND flags_in bit 1.
- R8: Negative (bit 2) is result bit 7. Overflow (bit 3) is two's-complement overflow of A - B - Cin. Sign (bit 4) is negative XOR overflow.
- R9: Codes 6 and 7 are reserved: result_we = 0, result = 0, and flags_out equals flags_in.
- R10: All outputs are registered and update one clock after the inputs are sampled. Synchronous reset clears result, result_we and flags_out to 0.
- R11: A compare followed by three compares with borrow, fed byte by byte with the flags chained, gives zero = (X == Y), carry = X < Y unsigned and sign = X < Y signed for the 32-bit values X and Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Operation select (0 sub, 1 sub-borrow, 2 cmp, 3 cmp-borrow, 4 sub-const, 5 sub-const-borrow) |
| src_a | input | 8 | Minuend |
| src_b | input | 8 | Register subtrahend |
| imm | input | 8 | Constant subtrahend for codes 4 and 5 |
| flags_in | input | 5 | Incoming flags {S,V,N,Z,C} |
| result | output | 8 | Registered difference |
| result_we | output | 1 | Write strobe for result |
| flags_out | output | 5 | Updated flags {S,V,N,Z,C} |

## Verification
Random operands over all eight codes, with random incoming flags, are compared against an integer reference. These cases separate borrow-in handling, constant selection and the zero-chaining rule, because the zero bit coming in is often clear while the byte result is zero. Directed bytes at 0x00, 0x7F, 0x80 and 0xFF hit the borrow and signed-overflow edges. Four-byte chains with equal words, words that differ only in the top or only in the bottom byte, and random words check whole-word equality against unsigned and signed ordering. A 16-bit add-by-constant through the two constant forms checks that the borrow carries across the byte boundary.

// File: rtl/sbc_alu_pkg.sv
package sbc_alu_pkg;

    typedef enum logic [2:0] {
        OP_SUB  = 3'd0,
        OP_SBC  = 3'd1,
        OP_CMP  = 3'd2,
        OP_CPC  = 3'd3,
        OP_SUBK = 3'd4,
        OP_SBCK = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

    typedef struct packed {
        logic legal;
        logic use_imm;
        logic use_cin;
        logic write;
        logic chain_z;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [2:0] code);
        alu_ctrl_t ctl;
        ctl = '0;
        case (alu_op_e'(code))
            OP_SUB:  begin ctl.legal = 1'b1; ctl.write = 1'b1; end
            OP_SBC:  begin ctl.legal = 1'b1; ctl.write = 1'b1; ctl.use_cin = 1'b1; ctl.chain_z = 1'b1; end
            OP_CMP:  begin ctl.legal = 1'b1; end
            OP_CPC:  begin ctl.legal = 1'b1; ctl.use_cin = 1'b1; ctl.chain_z = 1'b1; end
            OP_SUBK: begin ctl.legal = 1'b1; ctl.write = 1'b1; ctl.use_imm = 1'b1; end
            OP_SBCK: begin ctl.legal = 1'b1; ctl.write = 1'b1; ctl.use_imm = 1'b1; ctl.use_cin = 1'b1; ctl.chain_z = 1'b1; end
            default: ctl = '0;
        endcase
        return ctl;
    endfunction

endpackage

// File: rtl/sbc_operand_sel.sv
module sbc_operand_sel #(
    parameter int W = 8
) (
    input  logic         use_imm,
    input  logic [W-1:0] reg_val,
    input  logic [W-1:0] imm_val,
    output logic [W-1:0] operand
);
    always_comb begin
        operand = use_imm ? imm_val : reg_val;
    end
endmodule

// File: rtl/sbc_borrow_sub.sv
module sbc_borrow_sub #(
    parameter int W = 8
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    input  logic         borrow_in,
    output logic [W-1:0] diff,
    output logic         borrow_out,
    output logic         ovf
);
    logic [W:0] bchain;

    assign bchain[0] = borrow_in;

    for (genvar i = 0; i < W; i++) begin : g_cell
        // full subtractor cell
        assign diff[i]      = minuend[i] ^ subtrahend[i] ^ bchain[i];
        assign bchain[i+1]  = (~minuend[i] & subtrahend[i]) |
                              (~minuend[i] & bchain[i]) |
                              (subtrahend[i] & bchain[i]);
    end

    assign borrow_out = bchain[W];
    // signed overflow: borrow into msb differs from borrow out of msb
    assign ovf        = bchain[W] ^ bchain[W-1];
endmodule

// File: rtl/sbc_flag_gen.sv
module sbc_flag_gen
    import sbc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_ctrl_t    ctl,
    input  logic [W-1:0] diff,
    input  logic         borrow,
    input  logic         ovf,
    input  alu_flags_t   prev,
    output alu_flags_t   next
);
    logic byte_zero;

    always_comb begin
        byte_zero = (diff == '0);
        if (!ctl.legal) begin
            next = prev;
        end else begin
            next.c = borrow;
            next.z = byte_zero & (~ctl.chain_z | prev.z);
            next.n = diff[W-1];
            next.v = ovf;
            next.s = diff[W-1] ^ ovf;
        end
    end
endmodule

// File: rtl/sbc_alu.sv
module sbc_alu
    import sbc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [W-1:0] imm,
    input  logic [4:0]   flags_in,
    output logic [W-1:0] result,
    output logic         result_we,
    output logic [4:0]   flags_out
);
    alu_ctrl_t    ctl;
    alu_flags_t   fin;
    alu_flags_t   fnext;
    logic [W-1:0] rhs;
    logic [W-1:0] diff;
    logic         borrow;
    logic         ovf;
    logic         cin;

    always_comb begin
        ctl = decode_op(op_code);
        fin = alu_flags_t'(flags_in);
        cin = ctl.use_cin & fin.c;
    end

    sbc_operand_sel #(.W(W)) u_sel (
        .use_imm (ctl.use_imm),
        .reg_val (src_b),
        .imm_val (imm),
        .operand (rhs)
    );

    sbc_borrow_sub #(.W(W)) u_sub (
        .minuend    (src_a),
        .subtrahend (rhs),
        .borrow_in  (cin),
        .diff       (diff),
        .borrow_out (borrow),
        .ovf        (ovf)
    );

    sbc_flag_gen #(.W(W)) u_flags (
        .ctl    (ctl),
        .diff   (diff),
        .borrow (borrow),
        .ovf    (ovf),
        .prev   (fin),
        .next   (fnext)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            result_we <= 1'b0;
            flags_out <= '0;
        end else begin
            result    <= ctl.legal ? diff : '0;
            result_we <= ctl.legal & ctl.write;
            flags_out <= fnext;
        end
    end
endmodule

// File: rtl/sbc_alu_checker.sv
module sbc_alu_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   op_code,
    input logic [W-1:0] src_a,
    input logic [W-1:0] src_b,
    input logic [4:0]   flags_in,
    input logic [W-1:0] result,
    input logic         result_we,
    input logic [4:0]   flags_out
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    a_r10_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (result == '0 && !result_we && flags_out == '0));

    a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(op_code) == 3'd2 |-> !result_we);

    a_r4_cpc_no_write: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(op_code) == 3'd3 |-> !result_we);

    a_r1_sub_result: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(op_code) == 3'd0 |-> (result_we && result == W'($past(src_a) - $past(src_b))));

    a_r6_plain_borrow: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(op_code) == 3'd0 |-> flags_out[0] == ($past(src_b) > $past(src_a)));

    a_r7_zero_sticky: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(op_code) inside {3'd1, 3'd3, 3'd5} && !$past(flags_in[1])) |-> !flags_out[1]);

    a_r8_sign_rule: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(op_code) < 3'd6) |-> flags_out[4] == (flags_out[3] ^ flags_out[2]));

    a_r9_reserved_pass: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(op_code) >= 3'd6 |-> (!result_we && result == '0 && flags_out == $past(flags_in)));
endmodule

bind sbc_alu sbc_alu_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_code   (op_code),
    .src_a     (src_a),
    .src_b     (src_b),
    .flags_in  (flags_in),
    .result    (result),
    .result_we (result_we),
    .flags_out (flags_out)
);

// File: tb/sbc_alu_test.sv
`timescale 1ns/1ps
module sbc_alu_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_code = '0;
    logic [7:0] src_a = '0, src_b = '0, imm = '0;
    logic [4:0] flags_in = '0;
    logic [7:0] result;
    logic       result_we;
    logic [4:0] flags_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    sbc_alu uut (
        .clk(clk), .rst(rst), .op_code(op_code), .src_a(src_a), .src_b(src_b),
        .imm(imm), .flags_in(flags_in), .result(result), .result_we(result_we),
        .flags_out(flags_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference: returns {we, result[7:0], flags[4:0]}
    function automatic logic [13:0] model(input int op, input int a, input int b,
                                          input int k, input logic [4:0] fi);
        int rhs, cin, t, sa, sb, st, r;
        logic c, z, n, v;
        if (op >= 6) return {1'b0, 8'h00, fi};
        rhs = (op >= 4) ? k : b;
        cin = (op == 1 || op == 3 || op == 5) ? int'(fi[0]) : 0;
        t  = a - rhs - cin;
        r  = t & 255;
        c  = (t < 0);
        sa = (a > 127) ? a - 256 : a;
        sb = (rhs > 127) ? rhs - 256 : rhs;
        st = sa - sb - cin;
        v  = (st < -128) || (st > 127);
        n  = (r > 127);
        z  = (r == 0);
        if (cin != 0 || op == 1 || op == 3 || op == 5) z = z && fi[1];
        return {(op != 2 && op != 3), r[7:0], {n ^ v, v, n, z, c}};
    endfunction

    task automatic run_op(input int op, input int a, input int b, input int k,
                          input logic [4:0] fi, input string req);
        logic [13:0] e;
        @(negedge clk);
        op_code = op[2:0]; src_a = a[7:0]; src_b = b[7:0]; imm = k[7:0]; flags_in = fi;
        e = model(op, a, b, k, fi);
        @(posedge clk); #1;
        chk({req, " we"},     {31'd0, result_we}, {31'd0, e[13]});
        chk({req, " result"}, {24'd0, result},    {24'd0, e[12:5]});
        chk({req, " flags"},  {27'd0, flags_out}, {27'd0, e[4:0]});
    endtask

    // 32-bit compare chain, R11
    task automatic chain32(input logic [31:0] x, input logic [31:0] y);
        logic [4:0] fl;
        logic [32:0] d;
        fl = 5'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            op_code = (i == 0) ? 3'd2 : 3'd3;
            src_a = x[i*8 +: 8]; src_b = y[i*8 +: 8]; imm = 8'h5A; flags_in = fl;
            @(posedge clk); #1;
            fl = flags_out;
        end
        d = {1'b0, x} - {1'b0, y};
        chk("R11 chain zero",   {31'd0, fl[1]}, {31'd0, x == y});
        chk("R11 chain carry",  {31'd0, fl[0]}, {31'd0, x < y});
        chk("R11 chain sign",   {31'd0, fl[4]}, {31'd0, $signed(x) < $signed(y)});
        chk("R11 chain neg",    {31'd0, fl[2]}, {31'd0, d[31]});
        chk("R7 chain no write",{31'd0, result_we}, 32'd0);
    endtask

    initial begin
        logic [15:0] v16;
        logic [4:0]  fl;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset result", {24'd0, result}, 32'd0);
        chk("R10 reset we",     {31'd0, result_we}, 32'd0);
        chk("R10 reset flags",  {27'd0, flags_out}, 32'd0);
        @(negedge clk); rst = 1'b0;

        // directed corners
        run_op(0, 8'h00, 8'h01, 0, 5'b0, "R1 R6 borrow at zero");
        run_op(0, 8'h80, 8'h01, 0, 5'b0, "R8 overflow 80-01");
        run_op(0, 8'h7F, 8'hFF, 0, 5'b0, "R8 overflow 7F-FF");
        run_op(0, 8'h55, 8'h55, 0, 5'b11111, "R7 plain zero ignores zin");
        run_op(1, 8'h10, 8'h0F, 0, 5'b00001, "R2 R7 sbc zero with zin clear");
        run_op(1, 8'h10, 8'h0F, 0, 5'b00011, "R2 R7 sbc zero with zin set");
        run_op(1, 8'hFF, 8'hFF, 0, 5'b00001, "R6 borrow in forces borrow");
        run_op(2, 8'h20, 8'h30, 0, 5'b0, "R3 compare no write");
        run_op(3, 8'h30, 8'h30, 0, 5'b00011, "R4 cpc chained borrow");
        run_op(4, 8'h09, 8'hAA, 8'h0A, 5'b0, "R5 const ignores B");
        run_op(5, 8'h09, 8'h00, 8'h08, 5'b00011, "R5 const borrow");
        run_op(6, 8'h12, 8'h34, 8'h56, 5'b10101, "R9 reserved 6");
        run_op(7, 8'hFF, 8'h00, 8'h00, 5'b01010, "R9 reserved 7");

        // 16-bit add 5 via subtract-constant of 0xFFFB
        v16 = 16'h12FE;
        run_op(4, v16[7:0], 8'h00, 8'hFB, 5'b0, "R5 add5 low");
        fl = flags_out; v16[7:0] = result;
        run_op(5, v16[15:8], 8'h00, 8'hFF, fl, "R5 add5 high");
        v16[15:8] = result;
        chk("R5 add5 16-bit value", {16'd0, v16}, 32'h00001303);

        // chained 32-bit compares
        chain32(32'hDEADBEEF, 32'hDEADBEEF);
        chain32(32'h00000000, 32'h00000000);
        chain32(32'h10000000, 32'h00000000);
        chain32(32'h00000000, 32'h00000001);
        chain32(32'h80000000, 32'h7FFFFFFF);
        chain32(32'h12340000, 32'h12340001);
        for (int i = 0; i < 40; i++) chain32($urandom, $urandom);

        // random ops
        for (int i = 0; i < 400; i++)
            run_op(int'($urandom % 8), int'($urandom % 256), int'($urandom % 256),
                   int'($urandom % 256), 5'($urandom), "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule